// File: doc/BRIEF.md
# Event and Cycle Counter Bank

This block holds a bank of 32-bit event counters and one 64-bit cycle counter, all reached through a small register address space. Each event counter advances on a pulse at its own input. The cycle counter advances once per clock. Software sets, clears and polls the per-counter state through paired set and clear addresses, one pair for counting enable, one for interrupt enable and one for overflow status. A single global control register starts counting, stops it, or zeroes every counter.

To sample at a known count, software preloads a counter to a value close to its wrap point and then enables it. When the counter rolls over to zero, its overflow flag is latched. A registered level interrupt stays high while any flagged counter also has its interrupt enable set. To acknowledge, the handler reads the overflow status and writes that same value back to the overflow clear address.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every counter and every mask is zero and `irq` is low. Reading the control register at 0x400 returns the event counter count (parameter `NUM_EVT`, default 8) in bits 15:11 and zero in every other bit.
- R2: Writing the control register sets the global enable from write bit 0, so writing 0x1 starts counting and writing 0x0 stops it. Control read bit 0 returns the enable.
- R3: A control write with bits 2:1 = 2'b11 (value 0x6) zeroes all event counters and the cycle counter, and it clears the global enable.
- R4: Counting enable uses clear address 0x403 and set address 0x404. Interrupt enable uses 0x405 (clear) and 0x406 (set). A 1 in a written bit acts on that mask bit, and a 0 leaves it unchanged. Reading either address of a pair returns the mask.
- R5: Event counter i advances by one at a clock edge only when the global enable, counting-enable bit i and `evt_in[i]` are all high. The cycle counter advances at every edge where the global enable and counting-enable bit 31 are high.
- R6: Event counter n is read and written at 0x421 + 0x10·n. A write at the same edge as an increment wins over the increment.
- R7: The 64-bit cycle counter is read and written as its low word at 0x40A and its high word at 0x40B. Carry passes from the low word into the high word.
- R8: A counter that goes from all ones to zero sets its overflow bit (bit i for event counter i, bit 31 for the cycle counter) at that same edge. This holds even when a clear of that bit is written at that edge.
- R9: Overflow status is read at 0x408 (and at 0x407). Writing 1s to 0x408 sets bits. Writing a value read from the status back to 0x407 clears exactly those bits.
- R10: `irq` goes high one cycle after the OR over all bits of (overflow AND interrupt enable) becomes true, and it goes low one cycle after that OR goes false.
- R11: Mask bits with no counter behind them always read zero. Unmapped addresses also read zero. Read data appears on `reg_rdata` after the edge at which `reg_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Registered read data |
| evt_in | input | NUM_EVT | Per-counter event pulses |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after these corner cases:

- **Wrap in the same cycle as an acknowledge.** A design that lets the clear win would lose an overflow that happens at that moment.
- **Write in the same cycle as an event pulse.** A design that lets the increment win would return the preload plus one.
- **Carry from the low word into the high word of the cycle counter, and the full 64-bit wrap.** A design with a 32-bit carry or the flag on the wrong bit would show a stale high word or a missing bit 31.
- **Zero bits in set and clear writes, and writes to unimplemented bits.** A design that loads the whole word instead of acting only on the 1s would corrupt the masks, and one that keeps unimplemented bits would return ghost status bits.
- **Interrupt latency, exactly one cycle.** A design with a combinational or doubly registered interrupt shows up on the cycle the bench samples.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

   // Register map (12-bit word addresses)
   localparam logic [11:0] A_CTRL     = 12'h400;
   localparam logic [11:0] A_CEN_CLR  = 12'h403;
   localparam logic [11:0] A_CEN_SET  = 12'h404;
   localparam logic [11:0] A_IEN_CLR  = 12'h405;
   localparam logic [11:0] A_IEN_SET  = 12'h406;
   localparam logic [11:0] A_OVF_CLR  = 12'h407;
   localparam logic [11:0] A_OVF_SET  = 12'h408;
   localparam logic [11:0] A_CYC_LO   = 12'h40A;
   localparam logic [11:0] A_CYC_HI   = 12'h40B;
   localparam logic [11:0] A_EVT_BASE = 12'h421;
   localparam int          EVT_STRIDE = 16;

   // Bit positions
   localparam int CYC_BIT     = 31;
   localparam int NUMEV_LSB   = 11;
   localparam int NUMEV_W     = 5;
   localparam int CTL_EN      = 0;
   localparam int CTL_RST_EVT = 1;
   localparam int CTL_RST_CYC = 2;

   typedef struct packed {
      logic en;
      logic rst_evt;
      logic rst_cyc;
   } ctl_cmd_t;

endpackage

// File: rtl/perf_counter.sv
module perf_counter #(
   parameter int W  = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [DW-1:0] wdata,
   input  logic          inc,
   output logic [W-1:0]  cnt,
   output logic          wrap
);

   if (!(W == DW || W == 2*DW)) begin : g_bad_width
      $error("perf_counter: W must equal DW or 2*DW");
   end

   logic [W-1:0] cnt_q, cnt_d, wr_val;

   if (W > DW) begin : g_wide
      assign wr_val = {wr_hi ? wdata : cnt_q[W-1:DW],
                       wr_lo ? wdata : cnt_q[DW-1:0]};
   end else begin : g_narrow
      assign wr_val = wr_lo ? wdata : cnt_q;
   end

   always_comb begin
      cnt_d = cnt_q;
      wrap  = 1'b0;
      if (clr) begin
         cnt_d = '0;
      end else if (wr_lo || wr_hi) begin
         cnt_d = wr_val;
      end else if (inc) begin
         cnt_d = cnt_q + W'(1);
         wrap  = &cnt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt = cnt_q;

   // R5: no stimulus, no change
   a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr || wr_lo || wr_hi || inc) |=> $stable(cnt));
   // R6: a write beats an increment
   a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !clr) |=> cnt[DW-1:0] == $past(wdata));
   // R3: reset command zeroes
   a_r3_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);
   // R8: a wrap lands on zero
   a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt == '0);

endmodule

// File: rtl/perf_mask.sv
module perf_mask #(
   parameter int          W    = 32,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);

   logic [W-1:0] q_r, q_d, set_m, clr_m;

   assign set_m = set_we ? wdata : '0;
   assign clr_m = clr_we ? wdata : '0;
   // hardware set is applied last so it overrides a software clear
   assign q_d   = ((q_r & ~clr_m) | set_m | hw_set) & IMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_d;
   end

   assign q = q_r;

   // R8: hardware set wins over a clear in the same cycle
   a_r8_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set != '0) |=> ((q & $past(hw_set & IMPL)) == $past(hw_set & IMPL)));
   // R4: zero bits written leave the mask alone
   a_r4_zero_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_we || clr_we) && wdata == '0 && hw_set == '0) |=> $stable(q));
   // R4: a written clear bit is gone next cycle unless hardware set it
   a_r4_clear_acts: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((q & $past(wdata) & ~$past(hw_set)) == '0));

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank #(
   parameter int NUM_EVT = 8,
   parameter int EVT_W   = 32,
   parameter int CYC_W   = 64,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_wr,
   input  logic               reg_rd,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic               irq
);
   import perf_ctr_pkg::*;

   localparam logic [DATA_W-1:0] IMPL_MASK =
      (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_EVT) - DATA_W'(1));
   localparam logic [DATA_W-1:0] CTRL_ID =
      DATA_W'(NUM_EVT) << NUMEV_LSB;

   if (NUM_EVT < 1 || NUM_EVT > 31) begin : g_bad_num
      $error("perf_ctr_bank: NUM_EVT must be 1..31");
   end
   if (DATA_W != 32 || EVT_W != DATA_W) begin : g_bad_data
      $error("perf_ctr_bank: DATA_W and EVT_W must be 32");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("perf_ctr_bank: ADDR_W must be at least 12");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ref_a);
      return a == ADDR_W'(ref_a);
   endfunction

   // ---------------- control ----------------
   ctl_cmd_t cmd;
   logic     ctl_we, en_q;

   assign ctl_we      = reg_wr && hit(reg_addr, A_CTRL);
   assign cmd.en      = reg_wdata[CTL_EN];
   assign cmd.rst_evt = ctl_we && reg_wdata[CTL_RST_EVT];
   assign cmd.rst_cyc = ctl_we && reg_wdata[CTL_RST_CYC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (ctl_we) en_q <= cmd.en;
   end

   // ---------------- masks ----------------
   logic [DATA_W-1:0] cen, ien, ovf, wrap_vec;

   perf_mask #(.W(DATA_W), .IMPL(IMPL_MASK)) u_cen (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_wr && hit(reg_addr, A_CEN_SET)),
      .clr_we(reg_wr && hit(reg_addr, A_CEN_CLR)),
      .wdata(reg_wdata), .hw_set('0), .q(cen));

   perf_mask #(.W(DATA_W), .IMPL(IMPL_MASK)) u_ien (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_wr && hit(reg_addr, A_IEN_SET)),
      .clr_we(reg_wr && hit(reg_addr, A_IEN_CLR)),
      .wdata(reg_wdata), .hw_set('0), .q(ien));

   perf_mask #(.W(DATA_W), .IMPL(IMPL_MASK)) u_ovf (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_wr && hit(reg_addr, A_OVF_SET)),
      .clr_we(reg_wr && hit(reg_addr, A_OVF_CLR)),
      .wdata(reg_wdata), .hw_set(wrap_vec), .q(ovf));

   // ---------------- event counters ----------------
   logic [EVT_W-1:0]  evt_cnt  [NUM_EVT];
   logic [ADDR_W-1:0] evt_addr [NUM_EVT];
   logic [NUM_EVT-1:0] evt_wrap;

   for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
      assign evt_addr[n] = ADDR_W'(A_EVT_BASE) + ADDR_W'(n * EVT_STRIDE);
      perf_counter #(.W(EVT_W), .DW(DATA_W)) u_cnt (
         .clk(clk), .rst_n(rst_n),
         .clr(cmd.rst_evt),
         .wr_lo(reg_wr && reg_addr == evt_addr[n]),
         .wr_hi(1'b0),
         .wdata(reg_wdata),
         .inc(en_q && cen[n] && evt_in[n]),
         .cnt(evt_cnt[n]),
         .wrap(evt_wrap[n]));
   end

   // ---------------- cycle counter ----------------
   logic [CYC_W-1:0]  cyc_cnt;
   logic [DATA_W-1:0] cyc_hi;
   logic              cyc_wrap, cyc_wr_lo, cyc_wr_hi, cyc_inc;

   assign cyc_wr_lo = reg_wr && hit(reg_addr, A_CYC_LO);
   assign cyc_inc   = en_q && cen[CYC_BIT];

   if (CYC_W > DATA_W) begin : g_cyc_wide
      assign cyc_wr_hi = reg_wr && hit(reg_addr, A_CYC_HI);
      assign cyc_hi    = cyc_cnt[CYC_W-1:DATA_W];
   end else begin : g_cyc_narrow
      assign cyc_wr_hi = 1'b0;
      assign cyc_hi    = '0;
   end

   perf_counter #(.W(CYC_W), .DW(DATA_W)) u_cyc (
      .clk(clk), .rst_n(rst_n),
      .clr(cmd.rst_cyc),
      .wr_lo(cyc_wr_lo), .wr_hi(cyc_wr_hi),
      .wdata(reg_wdata),
      .inc(cyc_inc),
      .cnt(cyc_cnt),
      .wrap(cyc_wrap));

   assign wrap_vec = (DATA_W'(cyc_wrap) << CYC_BIT) | DATA_W'(evt_wrap);

   // ---------------- interrupt ----------------
   logic irq_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(ovf & ien);
   end
   assign irq = irq_q;

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_val, rdata_q;
   logic              rd_hit;

   always_comb begin
      rd_val = '0;
      rd_hit = 1'b1;
      case (reg_addr)
         ADDR_W'(A_CTRL):                       rd_val = CTRL_ID | DATA_W'(en_q);
         ADDR_W'(A_CEN_CLR), ADDR_W'(A_CEN_SET): rd_val = cen;
         ADDR_W'(A_IEN_CLR), ADDR_W'(A_IEN_SET): rd_val = ien;
         ADDR_W'(A_OVF_CLR), ADDR_W'(A_OVF_SET): rd_val = ovf;
         ADDR_W'(A_CYC_LO):                     rd_val = cyc_cnt[DATA_W-1:0];
         ADDR_W'(A_CYC_HI):                     rd_val = cyc_hi;
         default:                               rd_hit = 1'b0;
      endcase
      for (int n = 0; n < NUM_EVT; n++) begin
         if (reg_addr == evt_addr[n]) begin
            rd_val = evt_cnt[n];
            rd_hit = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_val;
   end
   assign reg_rdata = rdata_q;

   // R8: every wrapping counter has its overflow flag next cycle
   a_r8_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_vec != '0) |=> ((ovf & $past(wrap_vec)) == $past(wrap_vec)));
   // R10: no enabled overflow, interrupt low next cycle
   a_r10_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
      ((ovf & ien) == '0) |=> !irq);
   // R10: an enabled overflow raises the interrupt next cycle
   a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ((ovf & ien) != '0) |=> irq);
   // R5: enabled cycle counter steps by one
   a_r5_cycle_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_inc && !cyc_wr_lo && !cyc_wr_hi && !cmd.rst_cyc)
      |=> cyc_cnt == $past(cyc_cnt) + CYC_W'(1));
   // R11: unmapped reads return zero
   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !rd_hit) |=> reg_rdata == '0);
   // R11: unimplemented mask bits never read as one
   a_r11_impl_only: assert property (@(posedge clk) disable iff (!rst_n)
      ((ovf | cen | ien) & ~IMPL_MASK) == '0);

endmodule

// File: tb/sim_perf_ctr_bank.sv
module sim_perf_ctr_bank;
   localparam int NE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic [NE-1:0] evt_in = '0;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   logic [31:0] exp_cnt [NE];
   logic [31:0] cen_m;
   logic [31:0] rv;
   logic [7:0]  pat;

   always #5 clk = ~clk;

   perf_ctr_bank #(.NUM_EVT(NE)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .evt_in(evt_in), .irq(irq));

   function automatic logic [11:0] ea(input int n);
      return 12'h421 + 12'(n * 16);
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a; reg_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [NE-1:0] v);
      evt_in = v;
      @(posedge clk); @(negedge clk);
      evt_in = '0;
   endtask

   task automatic chk_all(input string tag);
      logic [31:0] d;
      for (int i = 0; i < NE; i++) begin
         rd(ea(i), d);
         chk(tag, {32'h0, d}, {32'h0, exp_cnt[i]});
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {63'h0, irq}, 64'h0);
      rd(12'h400, rv); chk("R1 ctrl id", {32'h0, rv}, 64'h4000);
      rd(12'h404, rv); chk("R1 cen", {32'h0, rv}, 64'h0);
      rd(12'h408, rv); chk("R1 ovf", {32'h0, rv}, 64'h0);
      rd(ea(3), rv);   chk("R1 cnt3", {32'h0, rv}, 64'h0);
      rd(12'h40A, rv); chk("R1 cyc", {32'h0, rv}, 64'h0);

      // R4 set/clear masks
      wr(12'h404, 32'hFFFF_FFFF);
      rd(12'h404, rv); chk("R4 cen set", {32'h0, rv}, 64'h8000_00FF);
      rd(12'h403, rv); chk("R4 cen via clr addr", {32'h0, rv}, 64'h8000_00FF);
      wr(12'h403, 32'h0);
      rd(12'h404, rv); chk("R4 clr zero no effect", {32'h0, rv}, 64'h8000_00FF);
      wr(12'h403, 32'h5);
      rd(12'h404, rv); chk("R4 cen clr", {32'h0, rv}, 64'h8000_00FA);
      wr(12'h404, 32'h0);
      rd(12'h404, rv); chk("R4 set zero no effect", {32'h0, rv}, 64'h8000_00FA);
      wr(12'h406, 32'h8000_0003);
      rd(12'h405, rv); chk("R4 ien set", {32'h0, rv}, 64'h8000_0003);
      wr(12'h405, 32'hFFFF_FFFF);
      rd(12'h406, rv); chk("R4 ien clr", {32'h0, rv}, 64'h0);

      // R11 unmapped reads
      rd(12'h401, rv); chk("R11 0x401", {32'h0, rv}, 64'h0);
      rd(12'h409, rv); chk("R11 0x409", {32'h0, rv}, 64'h0);
      rd(ea(NE), rv);  chk("R11 beyond last counter", {32'h0, rv}, 64'h0);
      rd(12'h422, rv); chk("R11 0x422", {32'h0, rv}, 64'h0);

      // R6 preload every event counter
      for (int i = 0; i < NE; i++) begin
         exp_cnt[i] = 32'(i) * 32'h0101_0101 + 32'h100;
         wr(ea(i), exp_cnt[i]);
      end
      chk_all("R6 preload readback");

      // R5 gating: cycle counter off, global off
      wr(12'h403, 32'h8000_0000);
      cen_m = 32'h0000_00FA;
      for (int k = 0; k < 3; k++) pulse('1);
      chk_all("R5 global disable holds");
      wr(12'h400, 32'h1);
      rd(12'h400, rv); chk("R2 enable readback", {32'h0, rv}, 64'h4001);
      for (int p = 0; p < 16; p++) begin
         pat = 8'(p * 53 + 7) ^ 8'(p << 2);
         pulse(pat);
         for (int i = 0; i < NE; i++)
            if (pat[i] && cen_m[i]) exp_cnt[i] = exp_cnt[i] + 32'h1;
      end
      chk_all("R5 pattern sweep");
      wr(12'h400, 32'h0);
      pulse('1); pulse('1);
      chk_all("R2 stop holds");
      rd(12'h40A, rv); chk("R5 cycle counter disabled", {32'h0, rv}, 64'h0);

      // R3 reset all
      wr(12'h400, 32'h6);
      for (int i = 0; i < NE; i++) exp_cnt[i] = 32'h0;
      chk_all("R3 counters zero");
      rd(12'h400, rv); chk("R3 enable cleared", {32'h0, rv}, 64'h4000);

      // R7 cycle counter
      wr(12'h40A, 32'hFFFF_FFFD);
      wr(12'h40B, 32'hFFFF_FFFF);
      rd(12'h40A, rv); chk("R7 cyc lo", {32'h0, rv}, 64'hFFFF_FFFD);
      rd(12'h40B, rv); chk("R7 cyc hi", {32'h0, rv}, 64'hFFFF_FFFF);
      wr(12'h404, 32'h8000_0000);
      wr(12'h400, 32'h1);
      @(negedge clk);
      wr(12'h400, 32'h0);            // two increments
      rd(12'h40A, rv); chk("R5 cycle two steps", {32'h0, rv}, 64'hFFFF_FFFF);
      rd(12'h408, rv); chk("R8 no early ovf", {32'h0, rv}, 64'h0);
      wr(12'h400, 32'h1);
      wr(12'h400, 32'h0);            // one increment: 64-bit wrap
      rd(12'h40A, rv); chk("R7 wrap lo", {32'h0, rv}, 64'h0);
      rd(12'h40B, rv); chk("R7 wrap hi", {32'h0, rv}, 64'h0);
      rd(12'h408, rv); chk("R8 cycle ovf bit31", {32'h0, rv}, 64'h8000_0000);
      wr(12'h407, rv);
      rd(12'h408, rv); chk("R9 ack cycle ovf", {32'h0, rv}, 64'h0);
      wr(12'h40A, 32'hFFFF_FFFF);
      wr(12'h40B, 32'h5);
      wr(12'h400, 32'h1);
      wr(12'h400, 32'h0);
      rd(12'h40B, rv); chk("R7 carry hi", {32'h0, rv}, 64'h6);
      rd(12'h40A, rv); chk("R7 carry lo", {32'h0, rv}, 64'h0);
      wr(12'h403, 32'h8000_0000);

      // R8 / R10 event wrap and interrupt
      wr(12'h404, 32'h3);
      wr(12'h406, 32'h2);
      wr(ea(0), 32'hFFFF_FFFF);
      wr(ea(1), 32'hFFFF_FFFF);
      wr(12'h400, 32'h1);
      pulse(8'h03);
      chk("R10 irq latency low", {63'h0, irq}, 64'h0);
      @(negedge clk);
      chk("R10 irq high", {63'h0, irq}, 64'h1);
      rd(12'h408, rv); chk("R8 event ovf", {32'h0, rv}, 64'h3);
      rd(ea(0), rv);   chk("R8 cnt0 wrapped", {32'h0, rv}, 64'h0);
      wr(12'h407, 32'h1);
      rd(12'h408, rv); chk("R9 clear only bit0", {32'h0, rv}, 64'h2);
      chk("R10 irq stays", {63'h0, irq}, 64'h1);
      wr(12'h405, 32'h2);
      @(negedge clk);
      chk("R10 irq drops", {63'h0, irq}, 64'h0);

      // R8 wrap beats clear
      wr(ea(0), 32'hFFFF_FFFF);
      evt_in = 8'h01;
      wr(12'h407, 32'h1);
      evt_in = '0;
      rd(12'h408, rv); chk("R8 wrap beats clear", {32'h0, rv}, 64'h3);
      wr(12'h407, rv);
      rd(12'h408, rv); chk("R9 write-back ack", {32'h0, rv}, 64'h0);

      // R6 write beats increment
      evt_in = 8'h02;
      wr(ea(1), 32'h1234);
      evt_in = '0;
      rd(ea(1), rv); chk("R6 write beats inc", {32'h0, rv}, 64'h1234);

      // R9 set address, R11 unimplemented bits
      wr(12'h408, 32'h8000_0004);
      rd(12'h408, rv); chk("R9 ovf set", {32'h0, rv}, 64'h8000_0004);
      wr(12'h406, 32'h4);
      chk("R10 irq not yet", {63'h0, irq}, 64'h0);
      @(negedge clk);
      chk("R10 irq from set", {63'h0, irq}, 64'h1);
      wr(12'h408, 32'h0000_0F00);
      rd(12'h408, rv); chk("R11 unimpl ovf bits", {32'h0, rv}, 64'h8000_0004);

      finish_run();
   end
endmodule